// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block keeps the processor's current execution priority and decides, at each instruction boundary, whether a pending device request may take the processor away from the code that is running. Requests arrive on eight lines, one per priority level from 0 (lowest) to 7 (highest). The highest pending line is compared with the running priority. A request wins only if its level is strictly above that priority. When a request wins, the block saves the old priority together with the processor status word on an internal last-in-first-out stack. It then raises the running priority to the accepted level and emits a vector index for that level.

Service routines can nest. A request at a higher level breaks into a routine that is already running. When a routine finishes, a return strobe pops the most recent entry and restores the priority and the status word together. Vector fetch, memory stacking and instruction sequencing belong to the surrounding core. Three strobes stand in for them: an instruction-boundary pulse, a return pulse, and the acknowledge output.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `cur_prio` is 0, `ack` and `rest_valid` are 0, `vec_idx` and `rest_status` are 0, and `ovf_err` is 0.
- R2: A request is accepted only in a cycle with `insn_done` high. Its level must also be strictly greater than `cur_prio`. A request at a level equal to or below `cur_prio` changes no output.
- R3: When several `irq_req` bits are set, bit i standing for level i, the highest-numbered set bit is the one considered. On acceptance, `vec_idx` equals that level.
- R4: Acceptance shows in the cycle after the boundary. `ack` is high for exactly that cycle, and in that same cycle `cur_prio` holds the accepted level.
- R5: A request above the level of an active service routine preempts it. Nesting continues upward while stack space remains.
- R6: A `ret_strobe` with a non-empty stack pops the newest entry. In the next cycle, `rest_valid` pulses for one cycle, `cur_prio` returns to the priority saved at the matching acceptance, and `rest_status` shows the `cur_status` captured at that acceptance.
- R7: A `ret_strobe` with an empty stack is ignored. No `rest_valid` follows, and `cur_prio` and `rest_status` keep their values.
- R8: When `ret_strobe` and `insn_done` are high in the same cycle, the return is carried out and no request is accepted in that cycle.
- R9: If an acceptable request arrives while the stack already holds `STACK_DEPTH` entries, no `ack` is given and `ovf_err` sets. `ovf_err` stays set until reset and blocks all later acceptance. Returns keep working while it is set.
- R10: With `insn_done` and `ret_strobe` both low, `ack`, `rest_valid` and `cur_prio` do not change, whatever the request lines show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Pending request per level, bit i = level i |
| insn_done | input | 1 | Current instruction has completed; interrupts may be taken |
| ret_strobe | input | 1 | Service routine has finished; restore saved state |
| cur_status | input | 16 | Processor status word to save on acceptance |
| ack | output | 1 | One-cycle acceptance pulse |
| vec_idx | output | 3 | Level of the last accepted request |
| cur_prio | output | 3 | Current execution priority |
| rest_valid | output | 1 | One-cycle pulse: saved state restored |
| rest_status | output | 16 | Status word restored by the last return |
| ovf_err | output | 1 | Sticky save-stack overflow flag |

## Verification
Acceptance and return are the two functions that can fall in the same cycle. A boundary pulse can come together with a return strobe while a higher request is pending. The bench provokes this with a directed case: a level-7 request at a boundary, held against an active level-6 routine, with a return strobe in the same cycle. The random stream also produces such cycles often, because the strobes are drawn independently. The reference model gives the return precedence. The cycle is judged correct when the next cycle shows `rest_valid` with the restored priority and no `ack`.

// File: rtl/nic_pkg.sv
package nic_pkg;

  localparam int NIC_LVL_W = 3;
  localparam int NIC_SW_W  = 16;
  localparam int NIC_DEPTH = 8;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_TAKE = 2'd1,
    EV_OVF  = 2'd2,
    EV_RET  = 2'd3
  } nic_event_e;

  // Decide what happens this cycle. A return strobe always owns the cycle.
  function automatic nic_event_e pick_event(
    input logic ret_req,
    input logic stack_empty,
    input logic boundary,
    input logic req_any,
    input logic outranks,
    input logic stack_full,
    input logic err_set
  );
    nic_event_e ev;
    ev = EV_IDLE;
    if (ret_req) begin
      if (!stack_empty) ev = EV_RET;
    end else if (boundary && req_any && outranks) begin
      if (err_set)         ev = EV_IDLE;
      else if (stack_full) ev = EV_OVF;
      else                 ev = EV_TAKE;
    end
    return ev;
  endfunction

endpackage

// File: rtl/nic_level_enc.sv
module nic_level_enc #(
  parameter int LVL_W   = 3,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic [NUM_LVL-1:0] req,
  output logic               any,
  output logic [LVL_W-1:0]   level
);

  logic [NUM_LVL-1:0] above;
  logic [NUM_LVL-1:0] grant;

  assign above[NUM_LVL-1] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NUM_LVL - 1; i++) begin : g_chain
      assign above[i] = above[i+1] | req[i+1];
    end
    for (i = 0; i < NUM_LVL; i++) begin : g_grant
      assign grant[i] = req[i] & ~above[i];
    end
  endgenerate

  assign any = |req;

  always_comb begin
    level = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (grant[k]) level = level | LVL_W'(k);
    end
  end

endmodule

// File: rtl/nic_save_stack.sv
module nic_save_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 19,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] fill;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;

  assign wr_idx = PTR_W'(fill);
  assign rd_idx = PTR_W'(fill - CNT_W'(1));
  assign empty  = (fill == '0);
  assign full   = (fill == CNT_W'(DEPTH));
  assign top    = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (push && !full) begin
      mem[wr_idx] <= din;
      fill        <= fill + CNT_W'(1);
    end else if (pop && !empty) begin
      fill <= fill - CNT_W'(1);
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int LVL_W       = NIC_LVL_W,
  parameter int SW_W        = NIC_SW_W,
  parameter int STACK_DEPTH = NIC_DEPTH,
  localparam int NUM_LVL    = 1 << LVL_W,
  localparam int ENTRY_W    = LVL_W + SW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic               insn_done,
  input  logic               ret_strobe,
  input  logic [SW_W-1:0]    cur_status,
  output logic               ack,
  output logic [LVL_W-1:0]   vec_idx,
  output logic [LVL_W-1:0]   cur_prio,
  output logic               rest_valid,
  output logic [SW_W-1:0]    rest_status,
  output logic               ovf_err
);

  logic               hi_any;
  logic [LVL_W-1:0]   hi_lvl;
  logic               stk_empty;
  logic               stk_full;
  logic [ENTRY_W-1:0] stk_top;
  logic [ENTRY_W-1:0] stk_din;
  nic_event_e         evt;

  // Named internal events, observed by the bound checker.
  logic take;
  logic ovf_hit;
  logic do_ret;

  nic_level_enc #(.LVL_W(LVL_W)) u_enc (
    .req   (irq_req),
    .any   (hi_any),
    .level (hi_lvl)
  );

  assign evt = pick_event(ret_strobe, stk_empty, insn_done, hi_any,
                          hi_lvl > cur_prio, stk_full, ovf_err);

  assign take    = (evt == EV_TAKE);
  assign ovf_hit = (evt == EV_OVF);
  assign do_ret  = (evt == EV_RET);
  assign stk_din = {cur_prio, cur_status};

  nic_save_stack #(.DEPTH(STACK_DEPTH), .W(ENTRY_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .pop   (do_ret),
    .din   (stk_din),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_prio    <= '0;
      vec_idx     <= '0;
      ack         <= 1'b0;
      rest_valid  <= 1'b0;
      rest_status <= '0;
      ovf_err     <= 1'b0;
    end else begin
      ack        <= take;
      rest_valid <= do_ret;
      if (take) begin
        cur_prio <= hi_lvl;
        vec_idx  <= hi_lvl;
      end
      if (do_ret) begin
        cur_prio    <= stk_top[ENTRY_W-1 -: LVL_W];
        rest_status <= stk_top[SW_W-1:0];
      end
      if (ovf_hit) ovf_err <= 1'b1;
    end
  end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int LVL_W = 3,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_done,
  input logic               ret_strobe,
  input logic               ack,
  input logic [LVL_W-1:0]   vec_idx,
  input logic [LVL_W-1:0]   cur_prio,
  input logic               rest_valid,
  input logic               ovf_err,
  input logic               take,
  input logic               ovf_hit,
  input logic               do_ret
);

  assert_vec_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> vec_idx == cur_prio);

  assert_accept_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cur_prio > $past(cur_prio));

  assert_ack_follows_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ack);

  assert_return_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rest_valid |-> cur_prio < $past(cur_prio));

  assert_return_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> !ack);

  assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && rest_valid));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_ovf_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> !ack);

  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_err && !ack);

  assert_ret_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> rest_valid);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_done && !ret_strobe) |=> (!ack && !rest_valid));

  assert_prio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !rest_valid) |-> $stable(cur_prio));

endmodule

bind nest_irq_ctrl nic_checker #(.LVL_W(LVL_W)) u_nic_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_done  (insn_done),
  .ret_strobe (ret_strobe),
  .ack        (ack),
  .vec_idx    (vec_idx),
  .cur_prio   (cur_prio),
  .rest_valid (rest_valid),
  .ovf_err    (ovf_err),
  .take       (take),
  .ovf_hit    (ovf_hit),
  .do_ret     (do_ret)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;

  localparam int BD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_req = '0;
  logic        insn_done = 1'b0;
  logic        ret_strobe = 1'b0;
  logic [15:0] cur_status = '0;
  logic        ack;
  logic [2:0]  vec_idx;
  logic [2:0]  cur_prio;
  logic        rest_valid;
  logic [15:0] rest_status;
  logic        ovf_err;

  always #10 clk = ~clk;

  nest_irq_ctrl #(.STACK_DEPTH(BD)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
    .ret_strobe(ret_strobe), .cur_status(cur_status), .ack(ack),
    .vec_idx(vec_idx), .cur_prio(cur_prio), .rest_valid(rest_valid),
    .rest_status(rest_status), .ovf_err(ovf_err)
  );

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // Reference model state
  int          m_prio;
  int          m_sp;
  int          m_stp [BD];
  logic [15:0] m_sts [BD];
  bit          m_ovf;
  bit          e_ack, e_rv;
  int          e_vec;
  logic [15:0] e_rs;
  string       cur_tag;

  function automatic int top_level(input logic [7:0] r);
    for (int i = 7; i >= 0; i--) if (r[i]) return i;
    return -1;
  endfunction

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_outputs();
    cmp(cur_tag, "ack", int'(ack), int'(e_ack));
    if (e_ack) cmp(cur_tag, "vec_idx", int'(vec_idx), e_vec);
    cmp(cur_tag, "cur_prio", int'(cur_prio), m_prio);
    cmp(cur_tag, "rest_valid", int'(rest_valid), int'(e_rv));
    cmp(cur_tag, "rest_status", int'(rest_status), int'(e_rs));
    cmp(cur_tag, "ovf_err", int'(ovf_err), int'(m_ovf));
  endtask

  task automatic model(input logic [7:0] r, input logic d, input logic rt, input logic [15:0] s);
    int lv;
    e_ack = 0;
    e_rv  = 0;
    if (rt) begin
      if (m_sp > 0) begin               // R6 pop, R7 empty ignored, R8 return owns cycle
        m_sp--;
        m_prio = m_stp[m_sp];
        e_rs   = m_sts[m_sp];
        e_rv   = 1;
      end
    end else if (d) begin
      lv = top_level(r);
      if (lv > m_prio && !m_ovf) begin  // R2 strict, R3 highest wins
        if (m_sp == BD) m_ovf = 1;      // R9
        else begin
          m_stp[m_sp] = m_prio;
          m_sts[m_sp] = s;
          m_sp++;
          m_prio = lv;
          e_vec  = lv;
          e_ack  = 1;
        end
      end
    end
  endtask

  task automatic step(input logic [7:0] r, input logic d, input logic rt,
                      input logic [15:0] s, input string tag);
    @(negedge clk);
    check_outputs();
    irq_req = r; insn_done = d; ret_strobe = rt; cur_status = s;
    model(r, d, rt, s);
    cur_tag = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq_req = '0; insn_done = 0; ret_strobe = 0; cur_status = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_prio = 0; m_sp = 0; m_ovf = 0;
    e_ack = 0; e_rv = 0; e_vec = 0; e_rs = '0;
    cur_tag = "R1";
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state is checked by the first step
    step(8'h10, 0, 0, 16'h1111, "R10");     // no boundary: ignored
    step(8'h00, 0, 0, 16'h0000, "R10");
    step(8'h08, 1, 0, 16'hA003, "R2");      // accept level 3
    step(8'h08, 1, 0, 16'hBBBB, "R2");      // equal level: ignored
    step(8'h04, 1, 0, 16'hCCCC, "R2");      // lower level: ignored
    step(8'h52, 1, 0, 16'hA006, "R3");      // levels 6,4,1 -> 6 (R5 nesting)
    step(8'h80, 1, 1, 16'hDDDD, "R8");      // return beats boundary
    step(8'h00, 0, 1, 16'h0000, "R6");      // back to 0, status A003
    step(8'h00, 0, 1, 16'h0000, "R7");      // empty: ignored
    step(8'h00, 0, 0, 16'h0000, "R7");
    step(8'h02, 1, 0, 16'h0001, "R5");
    step(8'h04, 1, 0, 16'h0002, "R5");
    step(8'h08, 1, 0, 16'h0003, "R5");
    step(8'h10, 1, 0, 16'h0004, "R5");      // stack now full (4)
    step(8'h20, 1, 0, 16'h0005, "R9");      // overflow
    step(8'h80, 1, 0, 16'h0007, "R9");      // blocked
    step(8'h00, 0, 1, 16'h0000, "R9");      // return still works
    step(8'h80, 1, 0, 16'h0008, "R9");      // still blocked after pop
    step(8'h00, 0, 0, 16'h0000, "R9");
    for (int seg = 0; seg < 20; seg++) begin
      do_reset();
      for (int n = 0; n < 200; n++) begin
        logic [7:0] r;
        r = 8'($urandom) & 8'($urandom);
        step(r, ($urandom % 10) < 6, ($urandom % 10) < 2, 16'($urandom), "R4");
      end
      step(8'h00, 0, 0, 16'h0000, "R4");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule